// File: doc/BRIEF.md
# Data-Processing Arithmetic/Logic Unit with Condition Flags

This block is the combinational execute stage of a 32-bit RISC core. It takes a 4-bit operation selector and two operands. The first operand is a register value. The second operand has already passed through the barrel shifter, and the shifter's carry-out arrives with it. From these, the block produces the operation result, a write-back enable and the next negative/zero/carry/overflow flag set.

Subtraction is done as addition. The subtrahend is inverted and a carry-in is added. The reverse forms swap the operand roles before this step. Carry and overflow for every arithmetic form come from one bitwise identity on the adder inputs and the sum. Four compare/test selectors only change the flags and never request a register write.

Flags change only when the core executes compressed 16-bit instructions or when the instruction's flag-set bit is on. A flag-setting instruction that targets the program counter while the core is in an exception mode also raises a request to copy the saved status back into the current status.

Top module: `dp_alu`

## Requirements
- R1: The selector encodes AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The logical results are: AND gives a&b, EOR gives a^b, ORR gives a|b, MOV gives b, BIC gives a&~b, MVN gives ~b.
- R2: SUB and CMP compute a+~b+1. RSB computes b+~a+1, so the second operand is the minuend.
- R3: SBC computes a+~b+C and RSC computes b+~a+C, where C is the incoming carry flag.
- R4: ADD and CMN compute a+b with carry-in 0. ADC computes a+b+C.
- R5: For arithmetic selectors with update enabled, let x and y be the adder inputs after swap and inversion, and r the sum. With ov = ~(x^y)&(x^r), V is ov[31] and C is (ov^x^y^r)[31]. C therefore equals the adder's carry out of bit 31.
- R6: For arithmetic selectors with update enabled, Z is set when r is zero and N is r[31].
- R7: For logical selectors (0,1,8,9,12..15) with update enabled, C is the shifter carry input, Z is set when the result is zero, N is result[31], and V keeps its incoming value.
- R8: Write enable is 0 for TST, TEQ, CMP and CMN, and 1 for the other twelve selectors. The result port still carries the computed value.
- R9: Flags update only when the compressed-state input or the flag-set bit is 1. Otherwise the flag output equals the flag input. Flag vectors are packed {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R10: The restore-status request is 1 exactly when the destination is the program counter, the flag-set bit is 1 and the exception-mode input is 1. The compressed-state input does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation selector |
| opA | input | 32 | First operand (register value) |
| opB | input | 32 | Second operand (shifter output) |
| shiftCarry | input | 1 | Carry-out of the barrel shifter |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| setFlags | input | 1 | Flag-set bit of the instruction |
| compactState | input | 1 | Core is executing 16-bit compressed instructions |
| dstIsPc | input | 1 | Destination register is the program counter |
| excMode | input | 1 | Core is in an exception mode |
| result | output | 32 | Operation result |
| writeEn | output | 1 | Request to write the result to the destination |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |
| restoreStatus | output | 1 | Request to copy the saved status into the current status |

## Verification
The checks sit in immediate form inside combinational logic. They assume that each input is a known 0 or 1 whenever the logic settles, so every check is skipped while any operand, selector or control input is unknown. The bench drives every input to a defined value before the first comparison and changes inputs only just after a rising edge. The checks and the scoreboard therefore only see values that have settled from a complete, known stimulus.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef enum logic [2:0] {
    LOG_AND  = 3'd0,
    LOG_EOR  = 3'd1,
    LOG_ORR  = 3'd2,
    LOG_PASS = 3'd3,
    LOG_BIC  = 3'd4,
    LOG_NOT  = 3'd5
  } logicSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      isArith;
    logic      swapOps;
    logic      invertY;
    cinSel_e   cinSel;
    logicSel_e logicSel;
    logic      updateFlags;
    logic      writeEn;
  } aluCtrl_t;

  // Flag positions inside the packed {N,Z,C,V} vector
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       setFlags,
  input  logic       compactState,
  input  logic       dstIsPc,
  input  logic       excMode,
  output aluCtrl_t   ctrl,
  output logic       restoreStatus
);

  aluOp_e op;
  assign op = aluOp_e'(opSel);

  always_comb begin
    ctrl             = '0;
    ctrl.cinSel      = CIN_ZERO;
    ctrl.logicSel    = LOG_AND;
    ctrl.updateFlags = compactState | setFlags;
    ctrl.writeEn     = 1'b1;
    unique case (op)
      OP_AND, OP_TST: ctrl.logicSel = LOG_AND;
      OP_EOR, OP_TEQ: ctrl.logicSel = LOG_EOR;
      OP_ORR:         ctrl.logicSel = LOG_ORR;
      OP_MOV:         ctrl.logicSel = LOG_PASS;
      OP_BIC:         ctrl.logicSel = LOG_BIC;
      OP_MVN:         ctrl.logicSel = LOG_NOT;
      OP_SUB, OP_CMP: begin
        ctrl.isArith = 1'b1; ctrl.invertY = 1'b1; ctrl.cinSel = CIN_ONE;
      end
      OP_RSB: begin
        ctrl.isArith = 1'b1; ctrl.invertY = 1'b1; ctrl.swapOps = 1'b1;
        ctrl.cinSel  = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.isArith = 1'b1; ctrl.invertY = 1'b1; ctrl.cinSel = CIN_FLAG;
      end
      OP_RSC: begin
        ctrl.isArith = 1'b1; ctrl.invertY = 1'b1; ctrl.swapOps = 1'b1;
        ctrl.cinSel  = CIN_FLAG;
      end
      OP_ADD, OP_CMN: begin
        ctrl.isArith = 1'b1; ctrl.cinSel = CIN_ZERO;
      end
      OP_ADC: begin
        ctrl.isArith = 1'b1; ctrl.cinSel = CIN_FLAG;
      end
      default: ;
    endcase
    if (op == OP_TST || op == OP_TEQ || op == OP_CMP || op == OP_CMN)
      ctrl.writeEn = 1'b0;
  end

  assign restoreStatus = dstIsPc & setFlags & excMode;

  // R8: the compare/test group (selector 8..11) never writes back
  always_comb begin
    if (!$isunknown(opSel) && opSel[3:2] == 2'b10)
      p_compare_no_write_r8: assert (!ctrl.writeEn);
  end

  // R2: the reverse forms are the only ones that swap the operands
  always_comb begin
    if (!$isunknown(opSel) && ctrl.swapOps)
      p_swap_only_reverse_r2: assert (ctrl.isArith && ctrl.invertY && opSel[1:0] == 2'b11);
  end

endmodule

// File: rtl/dp_alu_datapath.sv
module dp_alu_datapath
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              shiftCarry,
  input  logic [3:0]        flagsIn,
  output logic [WIDTH-1:0]  result,
  output logic [3:0]        flagsOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addX, addY, addYRaw, addSum, ovVec, carryVec, logicRes;
  logic             carryIn;

  // Adder input preparation: swap for reverse forms, invert for subtract forms
  always_comb begin
    addX    = ctrl.swapOps ? opB : opA;
    addYRaw = ctrl.swapOps ? opA : opB;
    addY    = ctrl.invertY ? ~addYRaw : addYRaw;
    unique case (ctrl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
  end

  assign addSum   = addX + addY + {{(WIDTH-1){1'b0}}, carryIn};
  assign ovVec    = ~(addX ^ addY) & (addX ^ addSum);
  assign carryVec = ovVec ^ addX ^ addY ^ addSum;

  always_comb begin
    unique case (ctrl.logicSel)
      LOG_EOR:  logicRes = opA ^ opB;
      LOG_ORR:  logicRes = opA | opB;
      LOG_PASS: logicRes = opB;
      LOG_BIC:  logicRes = opA & ~opB;
      LOG_NOT:  logicRes = ~opB;
      default:  logicRes = opA & opB;
    endcase
  end

  assign result = ctrl.isArith ? addSum : logicRes;

  always_comb begin
    flagsOut = flagsIn;
    if (ctrl.updateFlags) begin
      flagsOut[FLAG_N] = result[MSB];
      flagsOut[FLAG_Z] = (result == '0);
      if (ctrl.isArith) begin
        flagsOut[FLAG_C] = carryVec[MSB];
        flagsOut[FLAG_V] = ovVec[MSB];
      end else begin
        flagsOut[FLAG_C] = shiftCarry;
      end
    end
  end

  // R5: the identity-based carry agrees with a widened addition
  logic [WIDTH:0] wideSum;
  assign wideSum = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, carryIn};
  always_comb begin
    if (!$isunknown({opA, opB, flagsIn, ctrl}) && ctrl.isArith && ctrl.updateFlags)
      p_carry_matches_sum_r5: assert (flagsOut[FLAG_C] == wideSum[WIDTH]);
  end

  // R7: logical operations leave overflow alone
  always_comb begin
    if (!$isunknown({opA, opB, flagsIn, ctrl}) && !ctrl.isArith)
      p_logic_keeps_v_r7: assert (flagsOut[FLAG_V] == flagsIn[FLAG_V]);
  end

  // R6: a zero flag written by an update goes with an all-zero result
  always_comb begin
    if (!$isunknown({opA, opB, flagsIn, ctrl}) && ctrl.updateFlags && flagsOut[FLAG_Z])
      p_zero_means_zero_r6: assert (result == '0);
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             shiftCarry,
  input  logic [3:0]       flagsIn,
  input  logic             setFlags,
  input  logic             compactState,
  input  logic             dstIsPc,
  input  logic             excMode,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic [3:0]       flagsOut,
  output logic             restoreStatus
);

  aluCtrl_t ctrl;

  dp_alu_ctrl i_ctrl (
    .opSel        (opSel),
    .setFlags     (setFlags),
    .compactState (compactState),
    .dstIsPc      (dstIsPc),
    .excMode      (excMode),
    .ctrl         (ctrl),
    .restoreStatus(restoreStatus)
  );

  dp_alu_datapath #(.WIDTH(WIDTH)) i_datapath (
    .ctrl      (ctrl),
    .opA       (opA),
    .opB       (opB),
    .shiftCarry(shiftCarry),
    .flagsIn   (flagsIn),
    .result    (result),
    .flagsOut  (flagsOut)
  );

  assign writeEn = ctrl.writeEn;

  // R9: with neither enable set, flags pass through untouched
  always_comb begin
    if (!$isunknown({setFlags, compactState, flagsIn, opSel}) && !setFlags && !compactState)
      p_flags_hold_r9: assert (flagsOut == flagsIn);
  end

  // R10: a restore request needs the flag-set bit
  always_comb begin
    if (!$isunknown({setFlags, dstIsPc, excMode}) && restoreStatus)
      p_restore_needs_s_r10: assert (setFlags && dstIsPc && excMode);
  end

endmodule

// File: tb/test_dp_alu.sv
module test_dp_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic        setFlags = 1'b0, compactState = 1'b0, dstIsPc = 1'b0, excMode = 1'b0;
  logic [31:0] result;
  logic        writeEn, restoreStatus;
  logic [3:0]  flagsOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit driverDone = 0;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
    logic        rst;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu i_dp_alu (
    .opSel(opSel), .opA(opA), .opB(opB), .shiftCarry(shiftCarry),
    .flagsIn(flagsIn), .setFlags(setFlags), .compactState(compactState),
    .dstIsPc(dstIsPc), .excMode(excMode), .result(result), .writeEn(writeEn),
    .flagsOut(flagsOut), .restoreStatus(restoreStatus)
  );

  // Reference model built from the requirement text
  function automatic expItem_t model(string tag, logic [3:0] op, logic [31:0] a,
                                     logic [31:0] b, logic sc, logic [3:0] fi,
                                     logic s, logic th, logic pc, logic ex);
    expItem_t e;
    logic [32:0] wide;
    logic [31:0] x, y, r;
    logic cin, arith, c, v;
    arith = 1'b1; cin = 1'b0; x = a; y = b;
    case (op)
      4'd2, 4'd10: begin x = a; y = ~b; cin = 1'b1; end
      4'd3:        begin x = b; y = ~a; cin = 1'b1; end
      4'd6:        begin x = a; y = ~b; cin = fi[1]; end
      4'd7:        begin x = b; y = ~a; cin = fi[1]; end
      4'd4, 4'd11: begin x = a; y = b;  cin = 1'b0; end
      4'd5:        begin x = a; y = b;  cin = fi[1]; end
      default:     arith = 1'b0;
    endcase
    wide = {1'b0, x} + {1'b0, y} + {32'd0, cin};
    if (arith) r = wide[31:0];
    else case (op)
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd13:      r = b;
      4'd14:      r = a & ~b;
      default:    r = ~b;
    endcase
    c = arith ? wide[32] : sc;
    v = arith ? ((x[31] == y[31]) && (r[31] != x[31])) : fi[0];
    e.tag = tag;
    e.res = r;
    e.we  = !(op inside {4'd8, 4'd9, 4'd10, 4'd11});
    e.fl  = (s || th) ? {r[31], r == 32'd0, c, v} : fi;
    e.rst = pc && s && ex;
    return e;
  endfunction

  task automatic drive(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic sc, logic [3:0] fi, logic s, logic th, logic pc, logic ex);
    @(posedge clk);
    #1;
    opSel = op; opA = a; opB = b; shiftCarry = sc; flagsIn = fi;
    setFlags = s; compactState = th; dstIsPc = pc; excMode = ex;
    expQ.push_back(model(tag, op, a, b, sc, fi, s, th, pc, ex));
  endtask

  // Monitor: compare at the falling edge, half a period after stimulus
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        testsRun++;
        if (result !== e.res || writeEn !== e.we || flagsOut !== e.fl ||
            restoreStatus !== e.rst) begin
          testsFailed++;
          $display("FAIL %s: got res=%h we=%b fl=%b rst=%b, expected res=%h we=%b fl=%b rst=%b",
                   e.tag, result, writeEn, flagsOut, restoreStatus,
                   e.res, e.we, e.fl, e.rst);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    // Idle state: all-zero inputs select AND with no update
    drive("R1 idle", 4'd0, 32'h0, 32'h0, 1'b0, 4'b0000, 0, 0, 0, 0);
    // R1 logical results
    drive("R1 AND", 4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 4'b0000, 0, 0, 0, 0);
    drive("R1 EOR", 4'd1,  32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 4'b0000, 0, 0, 0, 0);
    drive("R1 ORR", 4'd12, 32'h1200_0034, 32'h0056_7800, 1'b0, 4'b0000, 0, 0, 0, 0);
    drive("R1 MOV", 4'd13, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b0, 4'b0000, 0, 0, 0, 0);
    drive("R1 BIC", 4'd14, 32'hFFFF_FFFF, 32'h0000_FF0F, 1'b0, 4'b0000, 0, 0, 0, 0);
    drive("R1 MVN", 4'd15, 32'h0,         32'h0000_0001, 1'b0, 4'b0000, 0, 0, 0, 0);
    // R2 subtract with carry-in 1
    drive("R2 SUB equal", 4'd2,  32'd5, 32'd5, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R2 SUB borrow", 4'd2, 32'd0, 32'd1, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R2 RSB swap", 4'd3,   32'd3, 32'd10, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R2 CMP", 4'd10,       32'd7, 32'd9, 1'b0, 4'b0010, 1, 0, 0, 0);
    // R3 carry-flag forms
    drive("R3 SBC c0", 4'd6, 32'd5, 32'd3, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R3 SBC c1", 4'd6, 32'd5, 32'd3, 1'b0, 4'b0010, 1, 0, 0, 0);
    drive("R3 RSC c0", 4'd7, 32'd3, 32'd5, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R3 RSC c1", 4'd7, 32'd3, 32'd5, 1'b0, 4'b0010, 1, 0, 0, 0);
    // R4 add forms
    drive("R4 ADD c ignored", 4'd4, 32'd1, 32'd2, 1'b0, 4'b0010, 1, 0, 0, 0);
    drive("R4 ADC c1", 4'd5, 32'd1, 32'd2, 1'b0, 4'b0010, 1, 0, 0, 0);
    drive("R4 CMN wrap", 4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 1, 0, 0, 0);
    // R5 overflow and carry corners
    drive("R5 ADD overflow", 4'd4, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R5 ADD neg overflow", 4'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R5 SUB overflow", 4'd2, 32'h8000_0000, 32'd1, 1'b0, 4'b0000, 1, 0, 0, 0);
    drive("R5 ADC carry chain", 4'd5, 32'hFFFF_FFFF, 32'd0, 1'b0, 4'b0010, 1, 0, 0, 0);
    // R6 N and Z
    drive("R6 negative", 4'd2, 32'd1, 32'd2, 1'b0, 4'b1101, 1, 0, 0, 0);
    // R7 logical flags: C from shifter, V kept
    drive("R7 TST zero", 4'd8, 32'hF0, 32'h0F, 1'b1, 4'b0001, 1, 0, 0, 0);
    drive("R7 TEQ neg", 4'd9, 32'h8000_0000, 32'h0, 1'b0, 4'b0011, 1, 0, 0, 0);
    drive("R7 MVN compact", 4'd15, 32'h0, 32'h0, 1'b1, 4'b0000, 0, 1, 0, 0);
    // R8 every selector's write enable
    for (int k = 0; k < 16; k++)
      drive("R8 sweep", k[3:0], 32'h1234_5678, 32'h0F0F_0F0F, k[0], 4'b0110, 1, 0, 0, 0);
    // R9 no update: flags pass through, even on overflow
    drive("R9 hold add", 4'd4, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'b0101, 0, 0, 0, 0);
    drive("R9 hold cmp", 4'd10, 32'd0, 32'd0, 1'b0, 4'b1010, 0, 0, 0, 0);
    drive("R9 compact update", 4'd2, 32'd0, 32'd0, 1'b0, 4'b0000, 0, 1, 0, 0);
    // R10 restore combinations
    drive("R10 all set", 4'd13, 32'd0, 32'h10, 1'b0, 4'b0000, 1, 0, 1, 1);
    drive("R10 no s", 4'd13, 32'd0, 32'h10, 1'b0, 4'b0000, 0, 1, 1, 1);
    drive("R10 no exc", 4'd13, 32'd0, 32'h10, 1'b0, 4'b0000, 1, 0, 1, 0);
    drive("R10 not pc", 4'd13, 32'd0, 32'h10, 1'b0, 4'b0000, 1, 0, 0, 1);
    // Mixed patterns over arithmetic selectors
    for (int k = 2; k < 8; k++) begin
      drive("R5 mix a", k[3:0], 32'h8000_0001, 32'h7FFF_FFFF, 1'b0, 4'b0010, 1, 0, 0, 0);
      drive("R6 mix b", k[3:0], 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b1, 4'b0000, 1, 0, 0, 0);
    end
    @(posedge clk);
    @(posedge clk);
    #1;
    while (expQ.size() > 0) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule